// File: doc/BRIEF.md
# Singleton Weighted-Average Defuzzifier

This block turns the firing strengths of a rule base's output sets into one crisp control value. Each output set is reduced to a single position on the output axis (its singleton). The crisp value approximates the centre of area: the mean of those positions, weighted by the strengths. A start pulse latches a vector of 8-bit strengths and a vector of 8-bit singleton positions. The unit then visits the sets in ascending index order, one per clock. For each set it adds strength times position to a numerator and the strength to a denominator. A set whose strength is zero adds no product.

After the last set a restoring divider forms the quotient, one bit per clock. The 8-bit result is presented with a single-cycle done pulse. It stays on the output until the next accepted start. A controller with fewer output sets (five, seven) drives zero strength on the unused entries. Those entries then have no effect on the result.

Top module: `wavg_defuzz`

## Requirements
- R1: After reset, crisp_o is 0 and done_o is 0.
- R2: Strengths and singletons are latched at the clock edge where start_i is accepted. Later changes on strength_i and singleton_i do not affect that run's result. Set k occupies bits [8k+7:8k] of each vector.
- R3: A set with zero strength contributes nothing, whatever its singleton position.
- R4: For a nonzero strength sum, crisp_o equals floor(sum(s_k*p_k) / sum(s_k)) over all sets.
- R5: When every strength is zero, crisp_o becomes 0 and done_o pulses N_SETS+1 cycles after the start edge.
- R6: When the strength sum is nonzero, done_o pulses for exactly one cycle, N_SETS+1+NUM_W cycles after the start edge (NUM_W = 19 for 8 sets).
- R7: crisp_o holds its value between done pulses while no start is accepted.
- R8: All eight sets at strength 255 and position 255 give 255, with no accumulator overflow.
- R9: A start pulse while a run is in progress is ignored. The run completes with its own data and timing, and no extra done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run when idle |
| strength_i | input | N_SETS*8 | Firing strength per output set |
| singleton_i | input | N_SETS*8 | Singleton position per output set |
| crisp_o | output | 8 | Crisp result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a start pulse that lands while a run is already under way. The stimulus applies it once during accumulation and once during division. In the same run, it changes the data inputs to values that would give a different answer. The bench counts the run's cycles while it does this. It then confirms that the latency and result belong to the first start and that no second done pulse appears. Floor rounding, skipped zero-strength sets that carry extreme positions, and a full-scale run that just misses accumulator overflow are each set up with handpicked vectors.

// File: rtl/wavg_pkg.sv
package wavg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_FIN  = 2'd2,
    ST_DIV  = 2'd3
  } wavg_state_e;
endpackage

// File: rtl/wavg_ctrl.sv
module wavg_ctrl
  import wavg_pkg::*;
#(
  parameter int N_SETS = 8,
  parameter int IDX_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             den_zero_i,
  input  logic             div_last_i,
  output wavg_state_e      state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             cap_o,
  output logic             acc_en_o,
  output logic             div_load_o,
  output logic             fin_zero_o,
  output logic             fin_div_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SETS - 1);

  wavg_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    cap_o      = 1'b0;
    acc_en_o   = 1'b0;
    div_load_o = 1'b0;
    fin_zero_o = 1'b0;
    fin_div_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        cap_o   = 1'b1;
        idx_d   = '0;
        state_d = ST_ACC;
      end
      ST_ACC: begin
        acc_en_o = 1'b1;
        if (idx_q == LAST_IDX) state_d = ST_FIN;
        else                   idx_d   = idx_q + 1'b1;
      end
      ST_FIN: begin
        if (den_zero_i) begin
          fin_zero_o = 1'b1;
          state_d    = ST_IDLE;
        end else begin
          div_load_o = 1'b1;
          state_d    = ST_DIV;
        end
      end
      ST_DIV: if (div_last_i) begin
        fin_div_o = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;

  AST_ORDER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACC && idx_q != LAST_IDX) |=> (state_q == ST_ACC && idx_q == $past(idx_q) + 1'b1)); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> !(state_q == ST_ACC && idx_q == '0)); // R9
endmodule

// File: rtl/wavg_accum.sv
module wavg_accum #(
  parameter int W     = 8,
  parameter int NUM_W = 19,
  parameter int DEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [W-1:0]     str_i,
  input  logic [W-1:0]     pos_i,
  output logic [NUM_W-1:0] num_o,
  output logic [DEN_W-1:0] den_o,
  output logic             den_zero_o
);
  logic [NUM_W-1:0] num_q;
  logic [DEN_W-1:0] den_q;
  logic [2*W-1:0]   prod;
  logic [NUM_W:0]   num_sum;
  logic [DEN_W:0]   den_sum;
  logic             live;

  assign live    = en_i && (str_i != '0);
  // multiplier is gated so a skipped set toggles no product bits
  assign prod    = live ? str_i * pos_i : '0;
  assign num_sum = {1'b0, num_q} + (NUM_W+1)'(prod);
  assign den_sum = {1'b0, den_q} + (DEN_W+1)'(str_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q <= '0;
      den_q <= '0;
    end else if (clr_i) begin
      num_q <= '0;
      den_q <= '0;
    end else if (live) begin
      num_q <= num_sum[NUM_W-1:0];
      den_q <= den_sum[DEN_W-1:0];
    end
  end

  assign num_o      = num_q;
  assign den_o      = den_q;
  assign den_zero_o = (den_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live |-> (!num_sum[NUM_W] && !den_sum[DEN_W])); // R8
  AST_SKIP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && str_i == '0 && !clr_i) |=> ($stable(num_q) && $stable(den_q))); // R3
endmodule

// File: rtl/wavg_divider.sv
module wavg_divider #(
  parameter int W     = 8,
  parameter int NUM_W = 19,
  parameter int DEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             last_o,
  output logic [W-1:0]     quot_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_W - 1);

  logic [DEN_W-1:0] rem_q;
  logic [NUM_W-1:0] dvd_q, dvd_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [DEN_W:0]   shifted, diff, rem_nxt;
  logic             ge;

  assign shifted = {rem_q, dvd_q[NUM_W-1]};
  assign ge      = shifted >= {1'b0, den_i};
  assign diff    = shifted - {1'b0, den_i};
  assign rem_nxt = ge ? diff : shifted;
  // quotient bits shift into the dividend register as its bits are consumed
  assign dvd_nxt = {dvd_q[NUM_W-2:0], ge};
  assign last_o  = busy_q && (cnt_q == LAST_CNT);
  assign quot_o  = dvd_nxt[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      dvd_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      rem_q  <= '0;
      dvd_q  <= num_i;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      rem_q  <= rem_nxt[DEN_W-1:0];
      dvd_q  <= dvd_nxt;
      cnt_q  <= cnt_q + 1'b1;
      busy_q <= !last_o;
    end
  end

  AST_REM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (rem_nxt[DEN_W] == 1'b0)); // R4
  AST_QUOT_FIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> (dvd_nxt[NUM_W-1:W] == '0)); // R4
endmodule

// File: rtl/wavg_defuzz.sv
module wavg_defuzz
  import wavg_pkg::*;
#(
  parameter int N_SETS = 8,
  parameter int W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [N_SETS*W-1:0] strength_i,
  input  logic [N_SETS*W-1:0] singleton_i,
  output logic [W-1:0]      crisp_o,
  output logic              done_o
);
  localparam int IDX_W = (N_SETS > 1) ? $clog2(N_SETS) : 1;
  localparam int DEN_W = W + IDX_W;
  localparam int NUM_W = 2 * W + IDX_W;

  wavg_state_e      state;
  logic [IDX_W-1:0] idx;
  logic             cap, acc_en, div_load, fin_zero, fin_div, den_zero, div_last;
  logic [W-1:0]     str_q [N_SETS];
  logic [W-1:0]     pos_q [N_SETS];
  logic [W-1:0]     cur_str, cur_pos, quot;
  logic [NUM_W-1:0] num;
  logic [DEN_W-1:0] den;
  logic [W-1:0]     crisp_q;
  logic             done_q;

  for (genvar k = 0; k < N_SETS; k++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        str_q[k] <= '0;
        pos_q[k] <= '0;
      end else if (cap) begin
        str_q[k] <= strength_i[k*W +: W];
        pos_q[k] <= singleton_i[k*W +: W];
      end
    end
  end

  assign cur_str = str_q[idx];
  assign cur_pos = pos_q[idx];

  wavg_ctrl #(.N_SETS(N_SETS), .IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .den_zero_i (den_zero),
    .div_last_i (div_last),
    .state_o    (state),
    .idx_o      (idx),
    .cap_o      (cap),
    .acc_en_o   (acc_en),
    .div_load_o (div_load),
    .fin_zero_o (fin_zero),
    .fin_div_o  (fin_div)
  );

  wavg_accum #(.W(W), .NUM_W(NUM_W), .DEN_W(DEN_W)) u_accum (
    .clk_i, .rst_ni,
    .clr_i      (cap),
    .en_i       (acc_en),
    .str_i      (cur_str),
    .pos_i      (cur_pos),
    .num_o      (num),
    .den_o      (den),
    .den_zero_o (den_zero)
  );

  wavg_divider #(.W(W), .NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk_i, .rst_ni,
    .load_i (div_load),
    .num_i  (num),
    .den_i  (den),
    .last_o (div_last),
    .quot_o (quot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crisp_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fin_zero || fin_div;
      if (fin_zero)     crisp_q <= '0;
      else if (fin_div) crisp_q <= quot;
    end
  end

  assign crisp_o = crisp_q;
  assign done_o  = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R6
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |=> $stable(crisp_q)); // R7
  AST_ZERO_DEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FIN && den_zero) |=> (done_q && crisp_q == '0)); // R5
  AST_ONE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fin_zero && fin_div)); // R4
endmodule

// File: tb/wavg_defuzz_bench.sv
module wavg_defuzz_bench;
  localparam int N  = 8;
  localparam int W  = 8;
  localparam int NUM_W = 19;
  localparam int LAT_FULL = N + 1 + NUM_W;
  localparam int LAT_ZERO = N + 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N*W-1:0] str_v = '0;
  logic [N*W-1:0] pos_v = '0;
  logic [W-1:0]   crisp;
  logic           done;
  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  wavg_defuzz #(.N_SETS(N), .W(W)) u_wavg_defuzz (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .strength_i(str_v), .singleton_i(pos_v),
    .crisp_o(crisp), .done_o(done)
  );

  function automatic int ref_val(input logic [N*W-1:0] s, input logic [N*W-1:0] p);
    int num = 0;
    int den = 0;
    for (int k = 0; k < N; k++) begin
      if (s[k*W +: W] != 0) begin
        num += int'(s[k*W +: W]) * int'(p[k*W +: W]);
        den += int'(s[k*W +: W]);
      end
    end
    return (den == 0) ? 0 : num / den;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic launch(input logic [N*W-1:0] s, input logic [N*W-1:0] p);
    @(negedge clk);
    str_v = s; pos_v = p; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    do begin
      @(posedge clk); #1; k++;
    end while (!done && k < 200);
  endtask

  task automatic run_case(input logic [N*W-1:0] s, input logic [N*W-1:0] p, input string req);
    int k;
    int e = ref_val(s, p);
    bit zero = (s == '0);
    launch(s, p);
    wait_done(k);
    check(k == (zero ? LAT_ZERO : LAT_FULL), {req, " latency"}, k, zero ? LAT_ZERO : LAT_FULL);
    check(int'(crisp) == e, {req, " value"}, crisp, e);
    @(posedge clk); #1;
    check(!done, "R6 done single cycle", done, 0);
  endtask

  function automatic logic [N*W-1:0] ramp(input int base, input int step);
    logic [N*W-1:0] v;
    for (int k = 0; k < N; k++) v[k*W +: W] = W'((base + k * step) & 255);
    return v;
  endfunction

  task automatic t_reset();
    check(crisp == 0, "R1 reset crisp", crisp, 0);
    check(done == 0,  "R1 reset done", done, 0);
  endtask

  task automatic t_basic();
    logic [N*W-1:0] s;
    s = '0; s[3*W +: W] = 8'd100; s[4*W +: W] = 8'd200;
    run_case(s, ramp(0, 32), "R4 two sets");
    run_case(ramp(10, 30), ramp(5, 35), "R4 ramp");
    s = '0; s[0 +: W] = 8'd1; s[W +: W] = 8'd2;
    run_case(s, ramp(0, 1), "R4 floor");
    s = '0; s[6*W +: W] = 8'd9;
    run_case(s, ramp(3, 20), "R4 single set");
  endtask

  task automatic t_skip_zero();
    logic [N*W-1:0] s, p;
    s = ramp(40, 25); p = ramp(20, 30);
    for (int k = 5; k < N; k++) begin s[k*W +: W] = 8'd0; p[k*W +: W] = 8'd255; end
    run_case(s, p, "R3 five-set");
    s = ramp(200, -20); p = ramp(0, 40);
    s[7*W +: W] = 8'd0; p[7*W +: W] = 8'd255;
    s[2*W +: W] = 8'd0; p[2*W +: W] = 8'd0;
    run_case(s, p, "R3 seven-set gaps");
  endtask

  task automatic t_all_zero();
    run_case('0, ramp(255, 0), "R5 zero strength");
  endtask

  task automatic t_full_scale();
    run_case({N{8'd255}}, {N{8'd255}}, "R8 full scale");
  endtask

  task automatic t_input_change();
    int k;
    logic [N*W-1:0] s = ramp(50, 10);
    logic [N*W-1:0] p = ramp(10, 15);
    int e = ref_val(s, p);
    launch(s, p);
    @(negedge clk);
    str_v = ramp(1, 0); pos_v = ramp(250, 0);
    wait_done(k);
    check(int'(crisp) == e, "R2 latched inputs", crisp, e);
  endtask

  task automatic t_busy_start();
    int k = 0;
    logic [N*W-1:0] s = ramp(30, 20);
    logic [N*W-1:0] p = ramp(100, 5);
    int e = ref_val(s, p);
    int extra = 0;
    launch(s, p);
    do begin
      @(posedge clk); #1; k++;
      if (k == 3 || k == 15) begin
        str_v = ramp(255, 0); pos_v = ramp(0, 0); start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end while (!done && k < 200);
    start = 1'b0;
    check(k == LAT_FULL, "R9 busy start latency", k, LAT_FULL);
    check(int'(crisp) == e, "R9 busy start value", crisp, e);
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (done) extra++;
    end
    check(extra == 0, "R9 no extra done", extra, 0);
  endtask

  task automatic t_hold();
    logic [W-1:0] held = crisp;
    int moved = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      str_v = ramp(i * 7, 3); pos_v = ramp(i * 11, 5);
      @(posedge clk); #1;
      if (crisp != held || done) moved++;
    end
    check(moved == 0, "R7 hold", moved, 0);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_basic();
    t_skip_zero();
    t_hold();
    t_all_zero();
    t_full_scale();
    t_input_change();
    t_busy_start();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule